// File: doc/BRIEF.md
# Deferred DMA Register Access Bridge

This block sits in front of the DMA channel registers of a legacy-compatible I/O space. Some channels have their state split between a central legacy DMA controller and a peripheral that owns the channel. Such a channel is handled as a deferred access. The first attempt to reach one of its registers is refused with a retry, and the access is recorded. The block then requests the bus as an initiator. Once it is granted, it runs byte-wide I/O cycles to the owning peripheral, and for one designated register also to the central controller. Read results are merged into a single value.

When the requester repeats exactly the same access, the block completes it. A read returns the merged value. A write is acknowledged, because its data has already been delivered. An access to channel 4, or to a channel whose base pointer has its enable bit clear, is not deferred. It is flagged as a pass-through so that the surrounding fabric routes it straight to the central controller. Only one deferred access is held at a time.

Top module: `deferred_dma_bridge`

## Requirements
- R1: A target access to an enabled channel other than 4, while no deferred access is held, is answered one cycle later with `t_retry`. It is latched, and `i_req` goes high in that same cycle.
- R2: `i_valid` stays low until `i_gnt` has been seen with `i_req` high. `i_req` then stays high until the final initiator cycle completes with `i_done`.
- R3: A peripheral cycle uses the address {base pointer bits [15:7], channel[2:0], register offset[3:0]}. A central controller cycle uses `CTRL_BASE` OR {channel, offset}, and with the default `CTRL_BASE` that is {9'b0, channel, offset}.
- R4: An access to channel 4, or to a channel whose base pointer bit 0 (the enable bit) is 0, is answered with `t_pass` one cycle later. It causes no retry and no initiator activity.
- R5: Byte enables 2'b11 produce two peripheral byte cycles, low byte first. Byte enables 2'b10 produce one cycle on the high byte, and any other value produces one cycle on the low byte.
- R6: For a read, each peripheral byte returned lands in its lane of the merged value, and the other lane is zero. At offset 4'hF, one further cycle reads the central controller after the peripheral cycles, and its byte is ORed into the first lane.
- R7: For a write, each peripheral cycle carries the matching byte of the original write data. At offset 4'hF, one further central controller write carries the first-lane byte.
- R8: Once the transfers are done, an access with the same address, command and byte enables is answered with `t_ack` one cycle later. `t_rdata` carries the merged value for a read and zero for a write, and the block becomes free again.
- R9: While a deferred access is still being transferred, any other deferred-channel access is retried. It does not replace the latched access.
- R10: After the transfers are done, a non-matching access is retried, and the merged value is kept for the later matching access.
- R11: After reset, `t_retry`, `t_ack`, `t_pass`, `i_req` and `i_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_req | input | 1 | One-cycle target access strobe |
| t_addr | input | 7 | {channel[2:0], register offset[3:0]} |
| t_write | input | 1 | 1 = write, 0 = read |
| t_be | input | 2 | Byte enables of the access |
| t_wdata | input | 16 | Write data of the access |
| t_retry | output | 1 | Access refused, try again |
| t_ack | output | 1 | Access completed |
| t_pass | output | 1 | Access is not deferred; route to central controller |
| t_rdata | output | 16 | Read data, valid with `t_ack` |
| i_req | output | 1 | Initiator bus request |
| i_gnt | input | 1 | Initiator bus grant |
| i_valid | output | 1 | Initiator I/O cycle presented |
| i_write | output | 1 | Initiator cycle direction |
| i_addr | output | 16 | Initiator I/O address |
| i_wdata | output | 8 | Initiator write byte |
| i_rdata | input | 8 | Initiator read byte |
| i_done | input | 1 | Current initiator cycle finished |
| bp_table | input | 128 | Eight 16-bit base pointers, channel c at bits [16c+15:16c], bit 0 is the enable bit |

## Verification
Random reads and writes go to every deferred channel, with all three byte-enable shapes, random offsets weighted toward 4'hF, and grant delays of zero to three cycles. The returned peripheral bytes vary per cycle, so lane placement, low-first ordering and the central OR each show up as distinct data. Directed cases cover the three kinds of refusal: a second access while the first is still pending, a non-matching repeat after completion, and a pass-through for channel 4 or a disabled channel. Each of these is told apart from an acknowledgement, and the latched access is checked to have survived.

// File: rtl/deferred_dma_bridge.sv
module deferred_dma_bridge #(
  parameter int IO_W = 16,
  parameter int NCH = 8,
  parameter int REG_W = 4,
  parameter int LEGACY_CH = 4,
  parameter logic [IO_W-1:0] CTRL_BASE = '0,
  parameter logic [REG_W-1:0] CTRL_REG = '1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            t_req,
  input  logic [$clog2(NCH)+REG_W-1:0]    t_addr,
  input  logic                            t_write,
  input  logic [1:0]                      t_be,
  input  logic [15:0]                     t_wdata,
  output logic                            t_retry,
  output logic                            t_ack,
  output logic                            t_pass,
  output logic [15:0]                     t_rdata,
  output logic                            i_req,
  input  logic                            i_gnt,
  output logic                            i_valid,
  output logic                            i_write,
  output logic [IO_W-1:0]                 i_addr,
  output logic [7:0]                      i_wdata,
  input  logic [7:0]                      i_rdata,
  input  logic                            i_done,
  input  logic [NCH*IO_W-1:0]             bp_table
);
  localparam int CH_W = $clog2(NCH);
  localparam int LOC_W = CH_W + REG_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER, S_DONE} st_t;
  st_t st;

  logic [LOC_W-1:0] l_addr;
  logic             l_wr;
  logic [1:0]       l_be;
  logic [15:0]      l_wd;
  logic [15:0]      merged;
  logic [1:0]       step;

  wire [CH_W-1:0]  t_ch   = t_addr[LOC_W-1:REG_W];
  wire [IO_W-1:0]  t_bp   = bp_table[t_ch*IO_W +: IO_W];
  wire             t_dist = (t_ch != CH_W'(LEGACY_CH)) && t_bp[0];
  wire             t_match = (st == S_DONE) && (t_addr == l_addr) &&
                             (t_write == l_wr) && (t_be == l_be);

  wire [CH_W-1:0]  l_ch    = l_addr[LOC_W-1:REG_W];
  wire [REG_W-1:0] l_reg   = l_addr[REG_W-1:0];
  wire [IO_W-1:0]  l_bp    = bp_table[l_ch*IO_W +: IO_W];
  wire             two     = (l_be == 2'b11);
  wire             hi_lane = (l_be == 2'b10);
  wire             has_ctl = (l_reg == CTRL_REG);
  wire [1:0]       n_per   = two ? 2'd2 : 2'd1;
  wire [1:0]       last    = has_ctl ? n_per : n_per - 2'd1;
  wire             is_ctl  = has_ctl && (step == n_per);
  wire             step_hi = two ? (step == 2'd1) : hi_lane;
  wire [7:0]       first_b = hi_lane ? l_wd[15:8] : l_wd[7:0];

  assign i_req   = (st == S_REQ) || (st == S_XFER);
  assign i_valid = (st == S_XFER);
  assign i_write = l_wr;
  assign i_addr  = is_ctl ? (CTRL_BASE | IO_W'(l_addr))
                          : {l_bp[IO_W-1:LOC_W], l_addr};
  assign i_wdata = is_ctl ? first_b : (step_hi ? l_wd[15:8] : l_wd[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      l_addr  <= '0;
      l_wr    <= 1'b0;
      l_be    <= '0;
      l_wd    <= '0;
      merged  <= '0;
      step    <= '0;
      t_retry <= 1'b0;
      t_ack   <= 1'b0;
      t_pass  <= 1'b0;
      t_rdata <= '0;
    end else begin
      t_retry <= 1'b0;
      t_ack   <= 1'b0;
      t_pass  <= 1'b0;
      t_rdata <= '0;

      if (t_req) begin
        if (!t_dist) begin
          t_pass <= 1'b1;
        end else if (t_match) begin
          t_ack   <= 1'b1;
          t_rdata <= l_wr ? 16'h0000 : merged;
          st      <= S_IDLE;
        end else begin
          t_retry <= 1'b1;
          if (st == S_IDLE) begin
            l_addr <= t_addr;
            l_wr   <= t_write;
            l_be   <= t_be;
            l_wd   <= t_wdata;
            merged <= '0;
            step   <= '0;
            st     <= S_REQ;
          end
        end
      end

      case (st)
        S_REQ: if (i_gnt) st <= S_XFER;
        S_XFER: if (i_done) begin
          if (!l_wr) begin
            if (is_ctl) begin
              if (hi_lane) merged[15:8] <= merged[15:8] | i_rdata;
              else         merged[7:0]  <= merged[7:0]  | i_rdata;
            end else if (step_hi) begin
              merged[15:8] <= i_rdata;
            end else begin
              merged[7:0] <= i_rdata;
            end
          end
          if (step == last) st <= S_DONE;
          else              step <= step + 2'd1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/deferred_dma_bridge_chk.sv
module deferred_dma_bridge_chk #(
  parameter int LOC_W = 7,
  parameter int CH_W = 3,
  parameter int LEGACY_CH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             t_req,
  input logic [LOC_W-1:0] t_addr,
  input logic             t_retry,
  input logic             t_ack,
  input logic             t_pass,
  input logic             i_req,
  input logic             i_gnt,
  input logic             i_valid,
  input logic             i_done
);
  logic seen_gnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      seen_gnt <= 1'b0;
    else if (!i_req) seen_gnt <= 1'b0;
    else if (i_gnt)  seen_gnt <= 1'b1;
  end

  p_valid_after_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |-> seen_gnt);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && !(i_valid && i_done)) |=> i_req);

  p_one_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t_retry, t_ack, t_pass}));

  p_resp_from_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (t_retry || t_ack || t_pass) |-> $past(t_req));

  p_legacy_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (t_req && (t_addr[LOC_W-1:LOC_W-CH_W] == CH_W'(LEGACY_CH))) |=> t_pass);

  p_ack_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    t_ack |-> (!i_req && !i_valid));
endmodule

bind deferred_dma_bridge deferred_dma_bridge_chk #(
  .LOC_W(LOC_W), .CH_W(CH_W), .LEGACY_CH(LEGACY_CH)
) u_chk (.*);

// File: tb/deferred_dma_bridge_tb.sv
module deferred_dma_bridge_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t_req = 1'b0, t_write = 1'b0;
  logic [6:0] t_addr = '0;
  logic [1:0] t_be = '0;
  logic [15:0] t_wdata = '0;
  logic t_retry, t_ack, t_pass;
  logic [15:0] t_rdata;
  logic i_req, i_valid, i_write;
  logic i_gnt = 1'b0, i_done = 1'b0;
  logic [15:0] i_addr;
  logic [7:0] i_wdata;
  logic [7:0] i_rdata = '0;
  logic [127:0] bp = '0;

  int checks = 0, errors = 0;
  logic [15:0] la[4];
  logic lw[4];
  logic [7:0] ld[4], lr[4];
  int n;
  logic early;

  always #5 clk = ~clk;

  deferred_dma_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .t_req(t_req), .t_addr(t_addr), .t_write(t_write),
    .t_be(t_be), .t_wdata(t_wdata), .t_retry(t_retry), .t_ack(t_ack),
    .t_pass(t_pass), .t_rdata(t_rdata), .i_req(i_req), .i_gnt(i_gnt),
    .i_valid(i_valid), .i_write(i_write), .i_addr(i_addr), .i_wdata(i_wdata),
    .i_rdata(i_rdata), .i_done(i_done), .bp_table(bp));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] ch, input logic [3:0] rg, input logic wr,
                        input logic [1:0] be, input logic [15:0] wd);
    t_req = 1'b1; t_addr = {ch, rg}; t_write = wr; t_be = be; t_wdata = wd;
    @(posedge clk); @(negedge clk);
    t_req = 1'b0;
  endtask

  task automatic serve(input int gdelay);
    n = 0; early = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (!i_req && !i_done) break;
      if (k < gdelay) begin
        i_gnt = 1'b0;
        if (i_valid) early = 1'b1;
      end else i_gnt = 1'b1;
      if (i_done) i_done = 1'b0;
      else if (i_valid) begin
        if (n < 4) begin
          la[n] = i_addr; lw[n] = i_write; ld[n] = i_wdata;
          lr[n] = 8'($urandom); i_rdata = lr[n];
        end
        n++;
        i_done = 1'b1;
      end
      @(posedge clk); @(negedge clk);
    end
    i_gnt = 1'b0;
    chk("R2 no cycle before grant", 32'(early), 32'd0);
  endtask

  function automatic logic [15:0] exp_rd(logic [3:0] rg, logic [1:0] be);
    logic [15:0] v = '0;
    int np = (be == 2'b11) ? 2 : 1;
    if (be == 2'b11) v = {lr[1], lr[0]};
    else if (be == 2'b10) v[15:8] = lr[0];
    else v[7:0] = lr[0];
    if (rg == 4'hF) begin
      if (be == 2'b10) v[15:8] = v[15:8] | lr[np];
      else v[7:0] = v[7:0] | lr[np];
    end
    return v;
  endfunction

  task automatic check_log(input logic [2:0] ch, input logic [3:0] rg, input logic wr,
                           input logic [1:0] be, input logic [15:0] wd);
    int np = (be == 2'b11) ? 2 : 1;
    logic [15:0] cbp = bp[ch*16 +: 16];
    logic [7:0] fb = (be == 2'b10) ? wd[15:8] : wd[7:0];
    chk("R5 R6 R7 cycle count", 32'(n), 32'(np + ((rg == 4'hF) ? 1 : 0)));
    for (int k = 0; k < np && k < n; k++) begin
      chk("R3 peripheral address", 32'(la[k]), 32'({cbp[15:7], ch, rg}));
      chk("R7 direction", 32'(lw[k]), 32'(wr));
      if (wr) chk("R5 R7 peripheral write byte", 32'(ld[k]),
                  32'((be == 2'b11) ? (k == 1 ? wd[15:8] : wd[7:0]) : fb));
    end
    if (rg == 4'hF && n > np) begin
      chk("R3 central address", 32'(la[np]), 32'({9'd0, ch, rg}));
      if (wr) chk("R7 central write byte", 32'(ld[np]), 32'(fb));
    end
  endtask

  task automatic txn(input logic [2:0] ch, input logic [3:0] rg, input logic wr,
                     input logic [1:0] be, input logic [15:0] wd, input int gd);
    access(ch, rg, wr, be, wd);
    chk("R1 first access retried", 32'({t_retry, t_ack, t_pass}), 32'b100);
    chk("R1 request raised", 32'(i_req), 32'd1);
    serve(gd);
    check_log(ch, rg, wr, be, wd);
    access(ch, rg, wr, be, wd);
    chk("R8 matching retry acked", 32'({t_retry, t_ack, t_pass}), 32'b010);
    chk("R8 R6 returned data", 32'(t_rdata), 32'(wr ? 16'h0 : exp_rd(rg, be)));
  endtask

  function automatic logic [2:0] pick_ch();
    logic [2:0] c = 3'($urandom_range(0, 6));
    return (c >= 3'd4) ? c + 3'd1 : c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 8; c++) bp[c*16 +: 16] = {7'($urandom), 2'b00, c[2:0], 3'b000, 1'b1};
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", 32'({t_retry, t_ack, t_pass, i_req, i_valid}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", 32'({t_retry, t_ack, t_pass, i_req, i_valid}), 32'd0);

    txn(3'd1, 4'hF, 1'b0, 2'b11, 16'h0000, 2);
    txn(3'd6, 4'hF, 1'b1, 2'b10, 16'hA55A, 0);
    txn(3'd0, 4'h2, 1'b1, 2'b11, 16'h1234, 1);
    txn(3'd7, 4'h3, 1'b0, 2'b01, 16'h0000, 3);

    access(3'd4, 4'h1, 1'b0, 2'b01, 16'h0);
    chk("R4 channel 4 passes", 32'({t_retry, t_ack, t_pass}), 32'b001);
    @(negedge clk);
    chk("R4 no initiator for channel 4", 32'(i_req), 32'd0);
    bp[2*16] = 1'b0;
    access(3'd2, 4'h5, 1'b1, 2'b01, 16'h0077);
    chk("R4 disabled channel passes", 32'({t_retry, t_ack, t_pass}), 32'b001);
    @(negedge clk);
    chk("R4 no initiator when disabled", 32'(i_req), 32'd0);
    bp[2*16] = 1'b1;

    access(3'd3, 4'h4, 1'b0, 2'b11, 16'h0);
    chk("R1 retry A", 32'(t_retry), 32'd1);
    access(3'd5, 4'h6, 1'b1, 2'b01, 16'h00EE);
    chk("R9 second access retried while pending", 32'({t_retry, t_ack, t_pass}), 32'b100);
    serve(2);
    check_log(3'd3, 4'h4, 1'b0, 2'b11, 16'h0);
    access(3'd3, 4'h4, 1'b0, 2'b01, 16'h0);
    chk("R10 mismatched byte enables retried", 32'({t_retry, t_ack, t_pass}), 32'b100);
    chk("R10 no new transfer", 32'(i_req), 32'd0);
    access(3'd3, 4'h4, 1'b1, 2'b11, 16'h0);
    chk("R10 mismatched command retried", 32'({t_retry, t_ack, t_pass}), 32'b100);
    access(3'd3, 4'h4, 1'b0, 2'b11, 16'h0);
    chk("R10 matching access acked", 32'({t_retry, t_ack, t_pass}), 32'b010);
    chk("R10 merged data kept", 32'(t_rdata), 32'(exp_rd(4'h4, 2'b11)));

    for (int i = 0; i < 40; i++) begin
      logic [1:0] be = 2'($urandom_range(1, 3));
      logic [3:0] rg = ($urandom_range(0, 2) == 0) ? 4'hF : 4'($urandom);
      txn(pick_ch(), rg, 1'($urandom), be, 16'($urandom), $urandom_range(0, 3));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule